// File: doc/BRIEF.md
# Configurable Dataflow Functional Unit

This block is the compute tile of a coarse-grained grid overlay. It sits between four neighbouring switches (north-west, north-east, south-west and south-east), takes two 16-bit operands from them, applies one of four integer operations and hands the result only to the south-east switch. A 16-bit configuration word is loaded before a kernel runs and stays fixed while it runs. The word picks the operation and, for each operand, either one neighbour or an 8-bit constant held in the word itself.

Every operand port has a two-entry holding queue and a credit-based handshake, so the two operands may arrive at different cycles and in any order. The output side keeps a credit counter towards the downstream switch. An operation starts only when both operands are present and the output holds a credit. Starting it consumes both operands, hands one credit back to each neighbour that supplied one, and sends the operands into a four-stage pipeline: one stage of balancing registers, one compute stage and two delay stages. A valid bit travels with the data and marks the result when it reaches the output.

Top module: `dfu_tile`

## Requirements
- R1: `cfg[15:14]` selects the operation: 00 gives A+B, 01 gives A-B, 10 gives the low 16 bits of A*B, 11 gives A|B. Add and subtract wrap modulo 2^16.
- R2: Operand A is taken from neighbour `cfg[12:11]` and operand B from neighbour `cfg[9:8]`. Neighbour index 0 is north-west, 1 north-east, 2 south-west and 3 south-east, and neighbour k uses `nb_data[16k+15:16k]` and `nb_valid[k]`. When both operands select the same neighbour, one flit feeds both of them.
- R3: `cfg[13]=1` makes A a constant and `cfg[10]=1` makes B a constant. The constant is `cfg[7:0]` zero-extended and is always present. The selected neighbour's `nb_valid` is then ignored and that neighbour gets no credit.
- R4: No result is produced while either non-constant operand is missing.
- R5: If the start condition holds in the cycle before rising edge k, `out_valid` is high with the result for exactly the one cycle that follows edge k+3, whatever the operation.
- R6: The output credit count is 2 after reset. It falls by one for each operation started and rises by one for each cycle with `out_credit_in` high. No operation starts while the count is zero.
- R7: In the cycle an operation starts, `nb_credit[k]` is high for one cycle for each neighbour k that supplied a consumed operand. Each neighbour may have at most 2 flits outstanding.
- R8: Each operand port holds up to two flits. Operands are paired and results come out in arrival order.
- R9: While `rst_n` is low, `out_valid` and `nb_credit` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 16 | Configuration word: operation, operand sources, constants |
| nb_data | input | 64 | Data from the four neighbours, 16 bits each |
| nb_valid | input | 4 | Flit present from each neighbour |
| nb_credit | output | 4 | Credit returned to each neighbour |
| out_data | output | 16 | Result to the south-east switch |
| out_valid | output | 1 | Result present |
| out_credit_in | input | 1 | Credit returned by the south-east switch |

## Verification
Assertions check four things on every cycle. A result appears exactly four cycles after its operation starts. Results in flight plus held credits never exceed the credit depth. No operand queue is written while it is full. A pair of constant operands never returns a credit. The bench sweeps every operation over every pairing of neighbours, including both operands on one neighbour, with corner values and skewed arrival order. Its scenarios alone show that the arithmetic is correct, that queued pairs keep their order, that an ignored handshake leaves the credits untouched and that output is blocked once the credits run out.

// File: rtl/dfu_tile.sv
module dfu_tile #(
  parameter int W       = 16,
  parameter int CREDITS = 2,
  localparam int CW     = $clog2(CREDITS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [15:0]    cfg,
  input  logic [4*W-1:0] nb_data,
  input  logic [3:0]     nb_valid,
  output logic [3:0]     nb_credit,
  output logic [W-1:0]   out_data,
  output logic           out_valid,
  input  logic           out_credit_in
);

  logic [1:0]   op;
  logic [1:0]   sel [2];
  logic         isc [2];
  logic [W-1:0] cval;
  assign op     = cfg[15:14];
  assign isc[0] = cfg[13];
  assign sel[0] = cfg[12:11];
  assign isc[1] = cfg[10];
  assign sel[1] = cfg[9:8];
  assign cval   = W'(cfg[7:0]);

  logic [W-1:0] q   [2][2];
  logic [1:0]   cnt [2];
  logic [W-1:0] din [2];
  logic [W-1:0] opnd[2];
  logic         push[2], pop[2], rdy[2];
  logic [CW-1:0] cred;
  logic         fire;

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      din[p]  = nb_data[sel[p]*W +: W];
      push[p] = !isc[p] && nb_valid[sel[p]];
      rdy[p]  = isc[p] || (cnt[p] != 2'd0);
      pop[p]  = fire && !isc[p];
      opnd[p] = isc[p] ? cval : q[p][0];
    end
  end

  assign fire = rst_n && rdy[0] && rdy[1] && (cred != '0);

  always_comb begin
    for (int i = 0; i < 4; i++)
      nb_credit[i] = (pop[0] && sel[0] == 2'(i)) || (pop[1] && sel[1] == 2'(i));
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (!rst_n) cnt[p] <= 2'd0;
      else if (push[p] && !pop[p]) begin
        q[p][cnt[p][0]] <= din[p];
        cnt[p] <= cnt[p] + 2'd1;
      end else if (!push[p] && pop[p]) begin
        q[p][0] <= q[p][1];
        cnt[p] <= cnt[p] - 2'd1;
      end else if (push[p] && pop[p]) begin
        if (cnt[p] == 2'd1) q[p][0] <= din[p];
        else begin
          q[p][0] <= q[p][1];
          q[p][1] <= din[p];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cred <= CW'(CREDITS);
    else cred <= cred - CW'(fire) + CW'(out_credit_in);
  end

  logic [W-1:0] ra, rb, d2, d3;
  logic [1:0]   rop;
  logic         v1, v2, v3;

  always_ff @(posedge clk) begin
    if (!rst_n) {v1, v2, v3, out_valid} <= '0;
    else {v1, v2, v3, out_valid} <= {fire, v1, v2, v3};
    ra  <= opnd[0];
    rb  <= opnd[1];
    rop <= op;
    case (rop)
      2'd0:    d2 <= ra + rb;
      2'd1:    d2 <= ra - rb;
      2'd2:    d2 <= ra * rb;
      default: d2 <= ra | rb;
    endcase
    d3       <= d2;
    out_data <= d3;
  end

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4) |-> (out_valid == $past(fire, 4)));

  p_inflight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({v1, v2, v3, out_valid}) + int'(cred)) <= CREDITS);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push[0] |-> cnt[0] != 2'd2) and (push[1] |-> cnt[1] != 2'd2));

  p_const_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[13] && cfg[10]) |-> (nb_credit == 4'd0));

endmodule

// File: tb/dfu_tile_tb.sv
module dfu_tile_tb;
  logic        clk = 0, rst_n = 0, out_credit_in = 0;
  logic [15:0] cfg = 16'h0000;
  logic [63:0] nb_data = '0;
  logic [3:0]  nb_valid = '0;
  logic [3:0]  nb_credit;
  logic [15:0] out_data;
  logic        out_valid;

  dfu_tile u_dut (.clk, .rst_n, .cfg, .nb_data, .nb_valid, .nb_credit,
                  .out_data, .out_valid, .out_credit_in);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, outs = 0;
  int sent[4], ret[4];
  bit ret_en = 1, extra = 0;
  logic [15:0] expq[$];
  string tagq[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] f(logic [1:0] op, logic [15:0] a, logic [15:0] b);
    logic [31:0] m;
    m = a * b;
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return m[15:0];
      default: return a | b;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) begin sent[i] = 0; ret[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (nb_credit[i]) ret[i]++;
      if (out_valid) begin
        outs++;
        if (expq.size() == 0) chk(0, "R5 unexpected result", out_data, 0);
        else begin
          logic [15:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(out_data == e, t, out_data, e);
        end
      end
      out_credit_in <= (ret_en && out_valid) || extra;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic send(int nb, logic [15:0] v);
    while (2 - sent[nb] + ret[nb] <= 0) tick();
    nb_data[nb*16 +: 16] = v;
    nb_valid[nb] = 1;
    sent[nb]++;
    tick();
    nb_valid[nb] = 0;
  endtask

  task automatic drain(string tag);
    int n = 0;
    while (expq.size() != 0 && n < 60) begin tick(); n++; end
    chk(expq.size() == 0, tag, expq.size(), 0);
    repeat (2) tick();
  endtask

  task automatic txn(logic [1:0] op, int as, int bs, logic [15:0] va, logic [15:0] vb,
                     int gap, bit bfirst);
    logic [15:0] b;
    b = (as == bs) ? va : vb;
    cfg = {op, 1'b0, 2'(as), 1'b0, 2'(bs), 8'h00};
    expq.push_back(f(op, va, b));
    tagq.push_back($sformatf("R1 R2 op=%0d a=%0d b=%0d", op, as, bs));
    if (as == bs) send(as, va);
    else if (bfirst) begin send(bs, vb); repeat (gap) tick(); send(as, va); end
    else begin send(as, va); repeat (gap) tick(); send(bs, vb); end
    drain("R2 drain");
    chk(sent[as] == ret[as], "R7 credits A", ret[as], sent[as]);
    chk(sent[bs] == ret[bs], "R7 credits B", ret[bs], sent[bs]);
  endtask

  function automatic logic [15:0] pa(int k);
    case (k) 0: return 16'hFFFF; 1: return 16'h8000; 2: return 16'h1234; default: return 16'h7FFF; endcase
  endfunction
  function automatic logic [15:0] pb(int k);
    case (k) 0: return 16'h0001; 1: return 16'h8000; 2: return 16'h00FF; default: return 16'hFFFF; endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base, c;
    repeat (5) tick();
    chk(out_valid == 0, "R9 out_valid in reset", out_valid, 0);
    chk(nb_credit == 0, "R9 nb_credit in reset", nb_credit, 0);
    rst_n = 1;
    tick();

    for (int op = 0; op < 4; op++)
      for (int as = 0; as < 4; as++)
        for (int bs = 0; bs < 4; bs++)
          for (int k = 0; k < 4; k++)
            txn(2'(op), as, bs, pa(k) ^ 16'(as * 16'h0111), pb(k) + 16'(bs), (as + k) % 3, k[0]);

    cfg = {2'd0, 1'b0, 2'd1, 1'b0, 2'd2, 8'h00};
    base = outs;
    send(1, 16'h0101);
    repeat (10) tick();
    chk(outs == base, "R4 no result with B missing", outs - base, 0);
    expq.push_back(16'h0304); tagq.push_back("R4 result after B");
    send(2, 16'h0203);
    drain("R4 drain");

    cfg = {2'd1, 1'b0, 2'd1, 1'b0, 2'd2, 8'h00};
    expq.push_back(16'h0010 - 16'h0003); tagq.push_back("R8 first pair");
    expq.push_back(16'h0100 - 16'h0020); tagq.push_back("R8 second pair");
    send(1, 16'h0010); send(1, 16'h0100);
    repeat (3) tick();
    send(2, 16'h0003); send(2, 16'h0020);
    drain("R8 drain");
    chk(sent[1] == ret[1] && sent[2] == ret[2], "R8 credits", ret[1] + ret[2], sent[1] + sent[2]);

    cfg = {2'd1, 1'b1, 2'd0, 1'b0, 2'd3, 8'h21};
    nb_data[15:0] = 16'hDEAD; nb_valid[0] = 1; tick(); nb_valid[0] = 0;
    repeat (4) tick();
    chk(expq.size() == 0, "R3 no early result", outs, 0);
    expq.push_back(16'h0021 - 16'h0005); tagq.push_back("R3 const A");
    send(3, 16'h0005);
    drain("R3 drain");
    chk(sent[0] == ret[0], "R3 ignored port no credit", ret[0], sent[0]);

    cfg = {2'd2, 1'b0, 2'd2, 1'b1, 2'd1, 8'hF3};
    nb_data[31:16] = 16'hBEEF; nb_valid[1] = 1; tick(); nb_valid[1] = 0;
    expq.push_back(f(2'd2, 16'h1111, 16'h00F3)); tagq.push_back("R3 const B");
    send(2, 16'h1111);
    drain("R3 drain B");
    chk(sent[1] == ret[1], "R3 ignored port B no credit", ret[1], sent[1]);

    ret_en = 0;
    base = outs;
    expq.push_back(16'h005A); tagq.push_back("R6 const result 1");
    expq.push_back(16'h005A); tagq.push_back("R6 const result 2");
    cfg = {2'd3, 1'b1, 2'd0, 1'b1, 2'd0, 8'h5A};
    c = 0;
    while (!out_valid && c < 10) begin @(negedge clk); c++; end
    chk(c == 4, "R5 latency", c, 4);
    repeat (20) tick();
    chk(outs - base == 2, "R6 stop at zero credit", outs - base, 2);
    expq.push_back(16'h005A); tagq.push_back("R6 after credit");
    extra = 1; tick(); extra = 0;
    repeat (15) tick();
    chk(outs - base == 3, "R6 one more per credit", outs - base, 3);
    cfg = 16'h0000;
    tick();
    extra = 1; tick(); tick(); extra = 0;
    repeat (3) tick();
    ret_en = 1;
    txn(2'd0, 0, 3, 16'hFFFF, 16'h0002, 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule